// File: doc/BRIEF.md
# AXI4-Lite to Register Bus Bridge

The bridge is an AXI4-Lite slave that turns each bus transaction into a single-cycle request on a simple internal register bus. A write becomes a one-cycle write request that carries a word address and a data word. A read becomes a one-cycle read request that carries a word address. The peripheral side answers each request with an acknowledge strobe, and for a read it returns the data in the same cycle as the acknowledge.

Only one access is in flight at any time. The bridge counts as busy from the moment it accepts an address until the master has taken the write or read response. While it is busy, every AXI ready line stays low. When a read and a write compete, the write always wins. This arbitration is deliberately unfair, because a steady stream of writes can hold off reads indefinitely.

The bridge does not decode addresses: the interconnect is trusted to send it only requests meant for it. The protection inputs are accepted and have no effect. The internal word address is taken from the AXI address with the two byte-offset bits removed, and its width is a parameter.

Top module: `axil_regbus_bridge`

## Requirements
- R1: After reset, s_bvalid, s_rvalid, reg_wr_req and reg_rd_req are 0, and s_awready, s_wready and s_arready are 1 while no AXI valid is high.
- R2: reg_wr_req is high for exactly one cycle, starting in the cycle after the later of the AW and W handshakes. In that cycle reg_wr_addr equals s_awaddr[REG_AW+1:2] and reg_wr_data equals the accepted s_wdata.
- R3: Once its AW (or W) handshake has been taken, s_awready (or s_wready) stays 0 until the B handshake completes. Both lines are 0 whenever an access is in progress.
- R4: In the cycle after reg_wr_ack is sampled high while a write waits, s_bvalid goes to 1 with s_bresp = 2'b00 (OKAY). It stays 1 until s_bready is sampled high.
- R5: reg_rd_req is high for exactly one cycle, starting in the cycle after the AR handshake, with reg_rd_addr equal to s_araddr[REG_AW+1:2].
- R6: reg_rd_data is captured only in the cycle in which reg_rd_ack is high. From the next cycle s_rvalid is 1, s_rdata holds the captured value and s_rresp = 2'b00. All three stay unchanged until s_rready is sampled high.
- R7: A write takes precedence over a read. s_arready is 0 whenever s_awvalid or s_wvalid is high, or an AW or W beat has been taken. A read presented in the same cycle as a write is accepted only after that write's B handshake.
- R8: Only one access is in flight. While s_bvalid or s_rvalid is high, no AXI ready line is high and no new register request is issued.
- R9: Address bits above REG_AW+1 and the byte-offset bits [1:0] do not change the access: no range check is made.
- R10: s_awprot and s_arprot have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | AXI_AW | Write byte address |
| s_awprot | input | 3 | Write protection attributes (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | AXI_AW | Read byte address |
| s_arprot | input | 3 | Read protection attributes (ignored) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code, always OKAY |
| reg_wr_req | output | 1 | One-cycle register write request |
| reg_wr_addr | output | REG_AW | Register word address for a write |
| reg_wr_data | output | DATA_W | Register write data |
| reg_wr_ack | input | 1 | Write acknowledge from the registers |
| reg_rd_req | output | 1 | One-cycle register read request |
| reg_rd_addr | output | REG_AW | Register word address for a read |
| reg_rd_data | input | DATA_W | Read data, valid with reg_rd_ack |
| reg_rd_ack | input | 1 | Read acknowledge from the registers |

## Verification
The assertions check on every cycle the rules that hold regardless of the scenario:
- the request strobes last a single cycle;
- s_bvalid and s_rvalid stay up with stable data until they are accepted;
- no ready line is high while a response is pending;
- s_arready yields to any write valid.

The ordering properties need the bench's scenarios and its behavioural model:
- the write-wins outcome of a same-cycle read and write;
- the read being held back until after the B handshake;
- the correct word address after the offset and upper bits are dropped;
- data that makes the round trip through the stub registers;
- protection values having no effect.

// File: rtl/regbus_bridge_pkg.sv
package regbus_bridge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_WAIT,
    ST_RD_WAIT,
    ST_WR_RESP,
    ST_RD_RESP
  } bridge_state_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/regbus_bridge_wcap.sv
// Captures the AW and W beats independently and reports when both are in.
module regbus_bridge_wcap #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle,
  input  logic              done,
  input  logic              awvalid,
  input  logic [REG_AW-1:0] aw_word,
  output logic              awready,
  input  logic              wvalid,
  input  logic [DATA_W-1:0] wdata,
  output logic              wready,
  output logic              aw_have,
  output logic              w_have,
  output logic              wr_go,
  output logic [REG_AW-1:0] word_addr,
  output logic [DATA_W-1:0] word_data
);
  logic aw_hs, w_hs;

  assign awready = idle && !aw_have;
  assign wready  = idle && !w_have;
  assign aw_hs   = awvalid && awready;
  assign w_hs    = wvalid && wready;
  assign wr_go   = idle && (aw_have || aw_hs) && (w_have || w_hs);

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_have   <= 1'b0;
      w_have    <= 1'b0;
      word_addr <= '0;
      word_data <= '0;
    end else if (done) begin
      aw_have <= 1'b0;
      w_have  <= 1'b0;
    end else begin
      if (aw_hs) begin
        aw_have   <= 1'b1;
        word_addr <= aw_word;
      end
      if (w_hs) begin
        w_have    <= 1'b1;
        word_data <= wdata;
      end
    end
  end

  AST_AW_CAPTURE_HELD: assert property (@(posedge clk) disable iff (rst)
    (aw_have && !done) |=> (aw_have && $stable(word_addr))); // R3
endmodule

// File: rtl/regbus_bridge_seq.sv
// Access sequencer: arbitration, request pulses and the AXI responses.
module regbus_bridge_seq
  import regbus_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic              aw_have,
  input  logic              w_have,
  input  logic              awvalid,
  input  logic              wvalid,
  input  logic              arvalid,
  input  logic [REG_AW-1:0] ar_word,
  output logic              arready,
  input  logic              bready,
  input  logic              rready,
  output logic              idle,
  output logic              wr_done,
  output logic              bvalid,
  output logic [1:0]        bresp,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              wr_req,
  input  logic              wr_ack,
  output logic              rd_req,
  output logic [REG_AW-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data_in,
  input  logic              rd_ack
);
  bridge_state_t state;

  assign idle    = (state == ST_IDLE);
  // Any sign of write activity holds the read channel off.
  assign arready = idle && !aw_have && !w_have && !awvalid && !wvalid;
  assign wr_done = bvalid && bready;
  assign bresp   = RESP_OKAY;
  assign rresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      wr_req  <= 1'b0;
      rd_req  <= 1'b0;
      bvalid  <= 1'b0;
      rvalid  <= 1'b0;
      rdata   <= '0;
      rd_addr <= '0;
    end else begin
      wr_req <= 1'b0;
      rd_req <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (wr_go) begin
            state  <= ST_WR_WAIT;
            wr_req <= 1'b1;
          end else if (arvalid && arready) begin
            state   <= ST_RD_WAIT;
            rd_req  <= 1'b1;
            rd_addr <= ar_word;
          end
        end
        ST_WR_WAIT: begin
          if (wr_ack) begin
            state  <= ST_WR_RESP;
            bvalid <= 1'b1;
          end
        end
        ST_RD_WAIT: begin
          if (rd_ack) begin
            state  <= ST_RD_RESP;
            rvalid <= 1'b1;
            rdata  <= rd_data_in;
          end
        end
        ST_WR_RESP: begin
          if (bready) begin
            state  <= ST_IDLE;
            bvalid <= 1'b0;
          end
        end
        ST_RD_RESP: begin
          if (rready) begin
            state  <= ST_IDLE;
            rvalid <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WREQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !wr_req); // R2
  AST_RREQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req); // R5
  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> bvalid); // R4
  AST_R_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata))); // R6
endmodule

// File: rtl/axil_regbus_bridge.sv
module axil_regbus_bridge #(
  parameter int AXI_AW = 32,
  parameter int DATA_W = 32,
  parameter int REG_AW = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [AXI_AW-1:0] s_awaddr,
  input  logic [2:0]        s_awprot,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [AXI_AW-1:0] s_araddr,
  input  logic [2:0]        s_arprot,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              reg_wr_req,
  output logic [REG_AW-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  input  logic              reg_wr_ack,
  output logic              reg_rd_req,
  output logic [REG_AW-1:0] reg_rd_addr,
  input  logic [DATA_W-1:0] reg_rd_data,
  input  logic              reg_rd_ack
);
  localparam int WORD_LO = 2;
  localparam int WORD_HI = REG_AW + WORD_LO - 1;

  logic idle, wr_done, wr_go, aw_have, w_have;
  logic [REG_AW-1:0] aw_word, ar_word;

  assign aw_word = s_awaddr[WORD_HI:WORD_LO];
  assign ar_word = s_araddr[WORD_HI:WORD_LO];

  // Byte offsets, protection and any bits above the word address are dropped.
  generate
    if (AXI_AW > WORD_HI + 1) begin : g_upper
      logic unused_addr_bits;
      assign unused_addr_bits = ^{s_awaddr[AXI_AW-1:WORD_HI+1], s_araddr[AXI_AW-1:WORD_HI+1],
                                  s_awaddr[WORD_LO-1:0], s_araddr[WORD_LO-1:0], s_awprot, s_arprot};
    end else begin : g_exact
      logic unused_addr_bits;
      assign unused_addr_bits = ^{s_awaddr[WORD_LO-1:0], s_araddr[WORD_LO-1:0], s_awprot, s_arprot};
    end
  endgenerate

  regbus_bridge_wcap #(.DATA_W(DATA_W), .REG_AW(REG_AW)) i_wcap (
    .clk       (clk),
    .rst       (rst),
    .idle      (idle),
    .done      (wr_done),
    .awvalid   (s_awvalid),
    .aw_word   (aw_word),
    .awready   (s_awready),
    .wvalid    (s_wvalid),
    .wdata     (s_wdata),
    .wready    (s_wready),
    .aw_have   (aw_have),
    .w_have    (w_have),
    .wr_go     (wr_go),
    .word_addr (reg_wr_addr),
    .word_data (reg_wr_data)
  );

  regbus_bridge_seq #(.DATA_W(DATA_W), .REG_AW(REG_AW)) i_seq (
    .clk        (clk),
    .rst        (rst),
    .wr_go      (wr_go),
    .aw_have    (aw_have),
    .w_have     (w_have),
    .awvalid    (s_awvalid),
    .wvalid     (s_wvalid),
    .arvalid    (s_arvalid),
    .ar_word    (ar_word),
    .arready    (s_arready),
    .bready     (s_bready),
    .rready     (s_rready),
    .idle       (idle),
    .wr_done    (wr_done),
    .bvalid     (s_bvalid),
    .bresp      (s_bresp),
    .rvalid     (s_rvalid),
    .rdata      (s_rdata),
    .rresp      (s_rresp),
    .wr_req     (reg_wr_req),
    .wr_ack     (reg_wr_ack),
    .rd_req     (reg_rd_req),
    .rd_addr    (reg_rd_addr),
    .rd_data_in (reg_rd_data),
    .rd_ack     (reg_rd_ack)
  );

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid || s_rvalid) |-> (!s_awready && !s_wready && !s_arready)); // R8
  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_req && reg_rd_req)); // R8
  AST_READ_YIELDS: assert property (@(posedge clk) disable iff (rst)
    (s_awvalid || s_wvalid) |-> !s_arready); // R7
endmodule

// File: tb/test_axil_regbus_bridge.sv
module test_axil_regbus_bridge;
  localparam int AXI_AW = 32;
  localparam int DATA_W = 32;
  localparam int REG_AW = 14;

  logic clk = 1'b0;
  logic rst;
  always #10 clk = ~clk;

  logic s_awvalid, s_awready, s_wvalid, s_wready, s_bvalid, s_bready;
  logic s_arvalid, s_arready, s_rvalid, s_rready;
  logic [AXI_AW-1:0] s_awaddr, s_araddr;
  logic [2:0] s_awprot, s_arprot;
  logic [DATA_W-1:0] s_wdata, s_rdata, reg_wr_data, reg_rd_data;
  logic [1:0] s_bresp, s_rresp;
  logic reg_wr_req, reg_wr_ack, reg_rd_req, reg_rd_ack;
  logic [REG_AW-1:0] reg_wr_addr, reg_rd_addr;

  axil_regbus_bridge #(.AXI_AW(AXI_AW), .DATA_W(DATA_W), .REG_AW(REG_AW)) i_axil_regbus_bridge (
    .clk(clk), .rst(rst),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awprot(s_awprot),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arprot(s_arprot),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .reg_wr_req(reg_wr_req), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .reg_wr_ack(reg_wr_ack),
    .reg_rd_req(reg_rd_req), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data), .reg_rd_ack(reg_rd_ack)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // master intentions
  bit want_aw, want_w, want_ar;
  logic [31:0] d_awaddr, d_wdata, d_araddr;
  logic [2:0] d_awprot, d_arprot;
  int b_delay, r_delay, bcnt, rcnt;
  logic [31:0] r_last;

  // stub register bank
  logic [31:0] mem [16];
  bit sw_pend, sr_pend;
  int sw_cd, sr_cd, wlat, rlat;
  logic [REG_AW-1:0] sw_addr, sr_addr;
  logic [31:0] sw_data;
  int wr_seen_cyc, rd_seen_cyc, b_hs_cyc, rd_req_count;

  // behavioural reference: 0 idle, 1 write wait, 2 read wait, 3 write resp, 4 read resp
  int m_state;
  bit m_awh, m_wh, m_wreq, m_rreq;
  logic [REG_AW-1:0] m_wa, m_ra;
  logic [31:0] m_wd, m_rd;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic cycle();
    bit e_awr, e_wr, e_arr, aw_hs, w_hs, ar_hs, b_hs, r_hs;
    @(negedge clk);
    cyc++;
    chk("R4 bvalid", s_bvalid, m_state == 3);
    if (s_bvalid) chk("R4 bresp okay", s_bresp, 2'b00);
    chk("R6 rvalid", s_rvalid, m_state == 4);
    if (m_state == 4) begin
      chk("R6 rdata", s_rdata, m_rd);
      chk("R6 rresp okay", s_rresp, 2'b00);
    end
    chk("R2 wr_req", reg_wr_req, m_wreq);
    if (m_wreq) begin
      chk("R2 wr_addr", reg_wr_addr, m_wa);
      chk("R2 wr_data", reg_wr_data, m_wd);
    end
    chk("R5 rd_req", reg_rd_req, m_rreq);
    if (m_rreq) chk("R5 rd_addr", reg_rd_addr, m_ra);
    // stub
    if (reg_wr_req) begin
      sw_pend = 1; sw_cd = wlat; sw_addr = reg_wr_addr; sw_data = reg_wr_data; wr_seen_cyc = cyc;
    end
    if (reg_rd_req) begin
      sr_pend = 1; sr_cd = rlat; sr_addr = reg_rd_addr; rd_seen_cyc = cyc; rd_req_count++;
    end
    reg_wr_ack = 1'b0;
    if (sw_pend) begin
      if (sw_cd == 0) begin
        reg_wr_ack = 1'b1; sw_pend = 0; mem[sw_addr[3:0]] = sw_data;
      end else sw_cd--;
    end
    reg_rd_ack = 1'b0;
    reg_rd_data = 32'hBAD0_0000 | cyc;
    if (sr_pend) begin
      if (sr_cd == 0) begin
        reg_rd_ack = 1'b1; sr_pend = 0; reg_rd_data = mem[sr_addr[3:0]];
      end else sr_cd--;
    end
    // master pins
    s_awvalid = want_aw; s_awaddr = d_awaddr; s_awprot = d_awprot;
    s_wvalid = want_w; s_wdata = d_wdata;
    s_arvalid = want_ar; s_araddr = d_araddr; s_arprot = d_arprot;
    if (s_bvalid) bcnt++; else bcnt = 0;
    if (s_rvalid) rcnt++; else rcnt = 0;
    s_bready = s_bvalid && (bcnt > b_delay);
    s_rready = s_rvalid && (rcnt > r_delay);
    #1;
    e_awr = (m_state == 0) && !m_awh;
    e_wr  = (m_state == 0) && !m_wh;
    e_arr = (m_state == 0) && !m_awh && !m_wh && !s_awvalid && !s_wvalid;
    chk("R3 awready", s_awready, e_awr);
    chk("R3 wready", s_wready, e_wr);
    chk("R7 arready", s_arready, e_arr);
    aw_hs = s_awvalid && e_awr;
    w_hs  = s_wvalid && e_wr;
    ar_hs = s_arvalid && e_arr;
    b_hs  = s_bvalid && s_bready;
    r_hs  = s_rvalid && s_rready;
    if (aw_hs) want_aw = 0;
    if (w_hs) want_w = 0;
    if (ar_hs) want_ar = 0;
    if (b_hs) b_hs_cyc = cyc;
    if (r_hs) r_last = s_rdata;
    m_wreq = 0; m_rreq = 0;
    case (m_state)
      0: begin
        if (aw_hs) begin m_awh = 1; m_wa = s_awaddr[REG_AW+1:2]; end
        if (w_hs) begin m_wh = 1; m_wd = s_wdata; end
        if (m_awh && m_wh) begin m_state = 1; m_wreq = 1; end
        else if (ar_hs) begin m_state = 2; m_rreq = 1; m_ra = s_araddr[REG_AW+1:2]; end
      end
      1: if (reg_wr_ack) m_state = 3;
      2: if (reg_rd_ack) begin m_state = 4; m_rd = reg_rd_data; end
      3: if (s_bready) begin m_state = 0; m_awh = 0; m_wh = 0; end
      4: if (s_rready) m_state = 0;
      default: m_state = 0;
    endcase
  endtask

  task automatic run_idle();
    for (int i = 0; i < 200; i++) begin
      cycle();
      if (!want_aw && !want_w && !want_ar && m_state == 0) break;
    end
    cycle();
  endtask

  task automatic put_write(input logic [31:0] a, input logic [31:0] d, input logic [2:0] p);
    d_awaddr = a; d_wdata = d; d_awprot = p; want_aw = 1; want_w = 1;
  endtask

  task automatic put_read(input logic [31:0] a, input logic [2:0] p);
    d_araddr = a; d_arprot = p; want_ar = 1;
  endtask

  initial begin
    int rc;
    rst = 1'b1;
    s_awvalid = 0; s_wvalid = 0; s_arvalid = 0; s_bready = 0; s_rready = 0;
    s_awaddr = '0; s_araddr = '0; s_wdata = '0; s_awprot = '0; s_arprot = '0;
    reg_wr_ack = 0; reg_rd_ack = 0; reg_rd_data = '0;
    d_awaddr = '0; d_araddr = '0; d_wdata = '0; d_awprot = '0; d_arprot = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    m_state = 0; m_wa = '0; m_ra = '0; m_wd = '0; m_rd = '0;
    wlat = 1; rlat = 1; b_delay = 0; r_delay = 0; bcnt = 0; rcnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cyc++;
    // R1 reset state
    chk("R1 bvalid", s_bvalid, 0);
    chk("R1 rvalid", s_rvalid, 0);
    chk("R1 wr_req", reg_wr_req, 0);
    chk("R1 rd_req", reg_rd_req, 0);
    chk("R1 awready", s_awready, 1);
    chk("R1 wready", s_wready, 1);
    chk("R1 arready", s_arready, 1);

    // AW first, W two cycles later
    d_awaddr = 32'h10; d_awprot = 0; want_aw = 1;
    cycle(); cycle();
    d_wdata = 32'h1111_1111; want_w = 1;
    b_delay = 2;
    run_idle();
    chk("R2 stub word 4", mem[4], 32'h1111_1111);

    // W first, AW later, slower acknowledge
    wlat = 2;
    d_wdata = 32'h2222_2222; want_w = 1;
    cycle();
    d_awaddr = 32'h24; want_aw = 1;
    run_idle();
    chk("R2 stub word 9", mem[9], 32'h2222_2222);

    // read back with delayed acceptance
    rlat = 1; r_delay = 2;
    put_read(32'h10, 0);
    run_idle();
    chk("R6 read back word 4", r_last, 32'h1111_1111);

    // simultaneous read and write: write wins, read waits for B handshake
    b_delay = 4; r_delay = 0; wlat = 0;
    rc = rd_req_count;
    put_write(32'h08, 32'h3333_3333, 0);
    put_read(32'h08, 0);
    run_idle();
    chk("R7 write issued before read", wr_seen_cyc < rd_seen_cyc, 1);
    chk("R8 read after B handshake", rd_seen_cyc > b_hs_cyc, 1);
    chk("R7 one read issued", rd_req_count, rc + 1);
    chk("R7 read sees new data", r_last, 32'h3333_3333);

    // R9 upper and offset bits dropped, R10 protection ignored
    b_delay = 0;
    put_write(32'hFFFF_000B, 32'h4444_4444, 3'b111);
    run_idle();
    chk("R9 high address maps to word 2", mem[2], 32'h4444_4444);
    put_read(32'h0000_0008, 3'b010);
    run_idle();
    chk("R10 read with prot", r_last, 32'h4444_4444);
    put_read(32'hABCD_0026, 3'b101);
    run_idle();
    chk("R9 read word 9 through high bits", r_last, 32'h2222_2222);

    // zero-latency acknowledges on both paths
    wlat = 0; rlat = 0;
    put_write(32'h3C, 32'h5A5A_A5A5, 0);
    run_idle();
    put_read(32'h3C, 0);
    run_idle();
    chk("R5 zero latency read", r_last, 32'h5A5A_A5A5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule